// File: doc/BRIEF.md
# Dual Interval Timer

This block holds two independent interval timers, each with a control word, a reload value and a live counter, reached over a small synchronous register bus. Software places a start value in the reload register and holds the counter on it with the hold-load bit. It then releases the hold and starts the count up or down.

When a counting timer steps past its terminal value (all ones counting up, zero counting down) it raises its interrupt flag. It then either reloads and keeps running, or halts at the terminal value. The single interrupt line is the OR over both timers of flag AND interrupt-enable. Software acknowledges a flag by writing a 1 to it, so writing back the control word just read clears a pending event. A start-both bit written to either control word starts both timers in the same cycle, which suits one timer used as a free-running timestamp.

Top module: `tmr_pair`

## Requirements
- R1: After reset every control, reload and counter register reads 0 and `irq` is 0.
- R2: While the hold-load bit (bit 5) is 1, the counter takes the timer's reload value on each clock edge, whatever the run bit says.
- R3: With hold-load 0 and run (bit 7) 1, the counter changes by one per clock: up when the direction bit (bit 1) is 0, down when it is 1.
- R4: With hold-load 0 and run 0, the counter keeps its value.
- R5: A running timer at all-ones (up) or at zero (down) sets its flag (bit 8) on the next edge.
- R6: On that step the counter takes the reload value and keeps running if auto-reload (bit 4) is 1. Otherwise the counter stays at the terminal value and the run bit clears.
- R7: Writing 1 to bit 8 clears the flag and writing 0 leaves it as it is. A terminal step in the same cycle as a clearing write leaves the flag set.
- R8: `irq` is 1 exactly when some timer has both its flag and its interrupt-enable bit (bit 6) at 1.
- R9: A control write with the start-both bit (bit 10) at 1 sets the run bit of both timers.
- R10: Control bits 0 to 7, 9 and 10 read back as last written, bit 8 reads the flag, and bits above 10 read 0.
- R11: The counter registers are read-only. A bus write to them changes no register.
- R12: Timer 0 has its control word at 0x00, its reload value at 0x04 and its counter at 0x08. Timer 1 has the same layout at 0x10, 0x14 and 0x18. Activity in one timer does not alter the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default parameters: two timers of 32 bits each, with a 5-bit address. Reload values placed one to three steps from a terminal value make both the up rollover and the down rollover, with and without auto-reload, happen within a few cycles. A reload of all ones makes a terminal step happen on every clock, so a clearing write is sure to land in the same cycle as a terminal step. Both timers exist, so the start-both bit, the OR in the interrupt and the independence of the two timers can all be observed at the ports.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CTRL_BITS = 11;

  // Register select within one timer window (byte address bits 3:2).
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_LOAD = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

  // Control word, MSB first: bit 10 down to bit 0.
  typedef struct packed {
    logic all_go;  // 10 start both timers
    logic pwm;     // 9  stored only
    logic flag;    // 8  event flag, write one to clear
    logic run;     // 7  count enable
    logic ien;     // 6  interrupt enable
    logic ldh;     // 5  hold counter on reload value
    logic rld;     // 4  auto-reload on terminal step
    logic cap;     // 3  stored only
    logic gen;     // 2  stored only
    logic dir;     // 1  1 = down
    logic mode;    // 0  stored only
  } ctrl_t;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg
  import tmr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wr_val,
  input  logic  all_set,
  input  logic  roll,
  output ctrl_t ctrl_q
);

  ctrl_t ctrl_nxt;
  logic  ctrl_upd;

  assign ctrl_upd = wr_en | all_set | roll;

  always_comb begin
    ctrl_nxt = ctrl_q;
    if (roll && !ctrl_q.rld) begin
      ctrl_nxt.run = 1'b0;
    end
    if (wr_en) begin
      ctrl_nxt      = wr_val;
      ctrl_nxt.flag = ctrl_q.flag & ~wr_val.flag;
    end
    if (all_set) begin
      ctrl_nxt.run = 1'b1;
    end
    if (roll) begin
      ctrl_nxt.flag = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_upd) begin
      ctrl_q <= ctrl_nxt;
    end
  end

  AST_FLAG_ON_ROLL: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> ctrl_q.flag); // R5
  AST_STOP_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (roll && !ctrl_q.rld && !wr_en && !all_set) |=> !ctrl_q.run); // R6
  AST_FLAG_W0_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_val.flag && ctrl_q.flag) |=> ctrl_q.flag); // R7
  AST_START_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    all_set |=> ctrl_q.run); // R9

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_wdata,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             roll
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_upd;
  logic             at_end;

  assign at_end  = ctrl.dir ? (cnt_q == CNT_ZERO) : (cnt_q == CNT_MAX);
  assign roll    = !ctrl.ldh && ctrl.run && at_end;
  assign cnt_upd = ctrl.ldh | ctrl.run;

  always_comb begin
    if (ctrl.ldh) begin
      cnt_nxt = load_q;
    end else if (roll) begin
      cnt_nxt = ctrl.rld ? load_q : cnt_q;
    end else if (ctrl.dir) begin
      cnt_nxt = cnt_q - CNT_ONE;
    end else begin
      cnt_nxt = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (load_we) begin
      load_q <= load_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_upd) begin
      cnt_q <= cnt_nxt;
    end
  end

  AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ldh |=> (cnt_q == $past(load_q))); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ctrl.ldh && !ctrl.dir && !roll) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run && !ctrl.ldh && ctrl.dir && !roll) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R3
  AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.run && !ctrl.ldh) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_pkg::*;
#(
  parameter int N_TMR  = 2,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 1,
  parameter int ADDR_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic                         bus_we,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  ctrl_t [N_TMR-1:0]            ctrl_rd,
  input  logic [N_TMR-1:0][DATA_W-1:0] load_rd,
  input  logic [N_TMR-1:0][DATA_W-1:0] cnt_rd,
  output logic [N_TMR-1:0]             ctrl_we,
  output logic [N_TMR-1:0]             load_we,
  output logic                         all_set,
  output logic [DATA_W-1:0]            rdata
);

  logic [IDX_W-1:0] idx;
  logic [1:0]       sel;
  logic             hit;

  assign idx = bus_addr[ADDR_W-1:4];
  assign sel = bus_addr[3:2];
  assign hit = (int'(idx) < N_TMR);

  for (genvar i = 0; i < N_TMR; i++) begin : g_dec
    assign ctrl_we[i] = bus_we && hit && (idx == IDX_W'(i)) && (sel == SEL_CTRL);
    assign load_we[i] = bus_we && hit && (idx == IDX_W'(i)) && (sel == SEL_LOAD);
  end

  assign all_set = bus_we && hit && (sel == SEL_CTRL) && bus_wdata[CTRL_BITS-1];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_TMR; i++) begin
      if (hit && (idx == IDX_W'(i))) begin
        case (sel)
          SEL_CTRL: rdata = DATA_W'(ctrl_rd[i]);
          SEL_LOAD: rdata = load_rd[i];
          SEL_CNT:  rdata = cnt_rd[i];
          default:  rdata = '0;
        endcase
      end
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_we, load_we})); // R12
  AST_CNT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel == SEL_CNT) |-> (ctrl_we == '0 && load_we == '0 && !all_set)); // R11

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter  int N_TMR  = 2,
  parameter  int CNT_W  = 32,
  localparam int IDX_W  = (N_TMR > 1) ? $clog2(N_TMR) : 1,
  localparam int ADDR_W = IDX_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq
);

  logic [1:0] rst_pipe;
  logic       rst_in_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_in_n = rst_pipe[1];

  ctrl_t [N_TMR-1:0]            ctrl_q;
  logic  [N_TMR-1:0][CNT_W-1:0] load_q;
  logic  [N_TMR-1:0][CNT_W-1:0] cnt_q;
  logic  [N_TMR-1:0]            ctrl_we;
  logic  [N_TMR-1:0]            load_we;
  logic  [N_TMR-1:0]            roll;
  logic                         all_set;
  ctrl_t                        wr_val;

  assign wr_val = ctrl_t'(bus_wdata[CTRL_BITS-1:0]);

  tmr_regif #(
    .N_TMR (N_TMR),
    .DATA_W(CNT_W),
    .IDX_W (IDX_W),
    .ADDR_W(ADDR_W)
  ) u_regif (
    .clk      (clk),
    .rst_n    (rst_in_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .ctrl_rd  (ctrl_q),
    .load_rd  (load_q),
    .cnt_rd   (cnt_q),
    .ctrl_we  (ctrl_we),
    .load_we  (load_we),
    .all_set  (all_set),
    .rdata    (bus_rdata)
  );

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    tmr_ctrl_reg u_ctrl (
      .clk    (clk),
      .rst_n  (rst_in_n),
      .wr_en  (ctrl_we[i]),
      .wr_val (wr_val),
      .all_set(all_set),
      .roll   (roll[i]),
      .ctrl_q (ctrl_q[i])
    );

    tmr_counter #(
      .CNT_W(CNT_W)
    ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_in_n),
      .ctrl      (ctrl_q[i]),
      .load_we   (load_we[i]),
      .load_wdata(bus_wdata),
      .load_q    (load_q[i]),
      .cnt_q     (cnt_q[i]),
      .roll      (roll[i])
    );
  end

  always_comb begin
    irq = 1'b0;
    for (int i = 0; i < N_TMR; i++) begin
      irq = irq | (ctrl_q[i].flag & ctrl_q[i].ien);
    end
  end

  AST_IRQ_AFTER_ROLL: assert property (@(posedge clk) disable iff (!rst_in_n)
    (roll[0] && ctrl_q[0].ien && !ctrl_we[0]) |=> irq); // R8
  AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_in_n |-> !irq); // R1

endmodule

// File: tb/sim_tmr_pair.sv
`timescale 1ns/1ps
module sim_tmr_pair;

  localparam real CLK_HALF = 2.5;
  localparam int  WD_CYC   = 100000;

  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks;
  int fails;
  bit done;

  tmr_pair u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_HALF) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.4;
    d = bus_rdata;
  endtask

  task automatic chk_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_reg("R1 t0 ctrl", 5'h00, 32'h0);
    chk_reg("R1 t0 load", 5'h04, 32'h0);
    chk_reg("R1 t0 cnt",  5'h08, 32'h0);
    chk_reg("R1 t1 ctrl", 5'h10, 32'h0);
    step();
    chk_reg("R1 t1 load", 5'h14, 32'h0);
    chk_reg("R1 t1 cnt",  5'h18, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_readback();
    wr(5'h10, 32'hFFFF_FA7F);
    chk_reg("R10 readback bits", 5'h10, 32'h0000_027F);
    wr(5'h10, 32'h0);
    chk_reg("R10 cleared", 5'h10, 32'h0);
  endtask

  task automatic t_load_count();
    wr(5'h04, 32'h1234);
    wr(5'h00, 32'h20);
    step();
    chk_reg("R2 held on reload", 5'h08, 32'h1234);
    wr(5'h04, 32'h55AA);
    step();
    chk_reg("R2 follows new reload", 5'h08, 32'h55AA);
    wr(5'h00, 32'hA0);
    step();
    step();
    chk_reg("R2 run ignored while held", 5'h08, 32'h55AA);
    wr(5'h00, 32'h80);
    chk_reg("R3 start", 5'h08, 32'h55AA);
    step();
    chk_reg("R3 up +1", 5'h08, 32'h55AB);
    step();
    chk_reg("R3 up +2", 5'h08, 32'h55AC);
    wr(5'h00, 32'h0);
    chk_reg("R4 stop value", 5'h08, 32'h55AE);
    step();
    step();
    chk_reg("R4 frozen", 5'h08, 32'h55AE);
    // down count, no reload, no interrupt enable
    wr(5'h04, 32'h3);
    wr(5'h00, 32'h20);
    wr(5'h00, 32'h82);
    chk_reg("R3 down start", 5'h08, 32'h3);
    step();
    chk_reg("R3 down -1", 5'h08, 32'h2);
    step();
    step();
    chk_reg("R3 down at zero", 5'h08, 32'h0);
    chk_reg("R5 no flag yet", 5'h00, 32'h82);
    step();
    chk_reg("R5 R6 flag set run cleared", 5'h00, 32'h102);
    chk_reg("R6 holds zero", 5'h08, 32'h0);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    step();
    chk_reg("R6 still zero", 5'h08, 32'h0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(5'h00, 32'h002);
    chk_reg("R7 write 0 keeps flag", 5'h00, 32'h102);
    wr(5'h00, 32'h042);
    chk_reg("R7 flag with ien", 5'h00, 32'h142);
    chk("R8 irq on", {31'b0, irq}, 32'h1);
    rd(5'h00, v);
    wr(5'h00, v);
    chk_reg("R7 write back acks", 5'h00, 32'h042);
    chk("R8 irq off", {31'b0, irq}, 32'h0);
    wr(5'h00, 32'h0);
  endtask

  task automatic t_set_wins();
    wr(5'h04, 32'hFFFF_FFFF);
    wr(5'h00, 32'h20);
    wr(5'h00, 32'h1D0);
    step();
    chk_reg("R6 reload keeps running", 5'h00, 32'h1D0);
    chk_reg("R6 reloaded value", 5'h08, 32'hFFFF_FFFF);
    chk("R8 irq from t0", {31'b0, irq}, 32'h1);
    wr(5'h00, 32'h1D0);
    chk_reg("R7 set beats clear", 5'h00, 32'h1D0);
    wr(5'h00, 32'h100);
    chk_reg("R7 set beats clear on stop", 5'h00, 32'h100);
    wr(5'h00, 32'h100);
    chk_reg("R7 cleared when idle", 5'h00, 32'h0);
    chk("R8 irq clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_start_both();
    wr(5'h04, 32'd100);
    wr(5'h14, 32'd200);
    wr(5'h00, 32'h20);
    wr(5'h10, 32'h20);
    wr(5'h10, 32'h00);
    wr(5'h00, 32'h400);
    chk_reg("R9 t0 ctrl", 5'h00, 32'h480);
    chk_reg("R9 t1 ctrl", 5'h10, 32'h080);
    chk_reg("R9 t0 cnt", 5'h08, 32'd100);
    chk_reg("R12 t1 cnt", 5'h18, 32'd200);
    step();
    chk_reg("R9 t0 counts", 5'h08, 32'd101);
    chk_reg("R9 t1 counts", 5'h18, 32'd201);
    wr(5'h00, 32'h0);
    wr(5'h10, 32'h0);
  endtask

  task automatic t_readonly();
    logic [31:0] c0;
    logic [31:0] c1;
    rd(5'h08, c0);
    rd(5'h18, c1);
    wr(5'h08, 32'hDEAD_BEEF);
    wr(5'h18, 32'hDEAD_BEEF);
    chk_reg("R11 t0 cnt kept", 5'h08, c0);
    chk_reg("R11 t1 cnt kept", 5'h18, c1);
    chk_reg("R11 t0 load kept", 5'h04, 32'd100);
    chk_reg("R11 t0 ctrl kept", 5'h00, 32'h0);
  endtask

  task automatic t_irq_t1();
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h10, 32'h20);
    wr(5'h10, 32'hC0);
    chk_reg("R12 t1 loaded", 5'h18, 32'hFFFF_FFFF);
    chk("R8 irq before roll", {31'b0, irq}, 32'h0);
    step();
    chk_reg("R5 R6 t1 flag run clear", 5'h10, 32'h140);
    chk("R8 irq from t1", {31'b0, irq}, 32'h1);
    chk_reg("R6 t1 holds max", 5'h18, 32'hFFFF_FFFF);
    chk_reg("R12 t0 untouched", 5'h00, 32'h0);
    step();
    chk_reg("R6 t1 still max", 5'h18, 32'hFFFF_FFFF);
    wr(5'h10, 32'h100);
    chk("R8 irq acked", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    #(CLK_HALF * 2.0 * WD_CYC);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks    = 0;
    fails     = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_readback();
    t_load_count();
    t_w1c();
    t_set_wins();
    t_start_both();
    t_readonly();
    t_irq_t1();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule